// File: doc/BRIEF.md
# ISDN TE layer-1 activation controller

This block is the terminal-side state machine for bringing an ISDN basic-rate S/T line up and taking it down again. It sees the line through a decoded signal code and a lost-framing flag, and it sees the host through a 4-bit command code. A host register holds that command code and keeps presenting it until software writes a new one. From these inputs the controller chooses which INFO signal the transmitter sends. It also keeps a 4-bit indication code for the host, pulses a strobe whenever that code changes, and raises an activated flag once the line is fully up.

Activation can be started by the terminal (an activation request naming D-channel priority class 8 or 10) or by the network (any non-INFO-0 signal arriving). The request is supervised by timer T3, which is counted in ticks delivered on an input pin. A reset command is honoured in every state. Three test transmissions (continuous pulses, isolated pulses and a looped INFO 3) can be entered only from the deactivated state and are left with a clock-enable, deactivate or reset command. Line coding, the analog front end and frame alignment sit outside this block.

Top module: `isdn_te_act_ctrl`

## Requirements
- R1: After reset the block is deactivated (F3): tx_info = 0 (INFO 0), ind_code = 4'hF, ind_stb = 0, activated = 0.
- R2: In F3 with host_cmd = 4'hC (clock enable) and rx_sig = 0 (INFO 0), the block stays in F3, sends INFO 0 and reports indication 4'h7.
- R3: In F3 with rx_sig = 0, an activation request (host_cmd = 4'h8 for class 8, 4'h9 for class 10) moves to F4 at the next edge; F4 sends tx_info = 1 (INFO 1) and reports 4'h1.
- R4: In F3 or F4, a non-INFO-0 line signal (rx_sig = 1, 2 or 3) moves to F5 at the next clock edge. F5 sends INFO 0 and reports 4'h2.
- R5: From F5, rx_sig = 2 (INFO 2) moves to F6, which sends tx_info = 3 (INFO 3) and reports 4'h4. rx_sig = 3 (INFO 4) in F5 or F6 moves to F7.
- R6: F7 sends INFO 3, drives activated = 1 and reports 4'hA if the last activation request was class 10. Otherwise it reports 4'h8. In F7, rx_sig = 2 returns the block to F6.
- R7: T3 counts t3_tick pulses while in F4, F5 or F6 and keeps its count across those states. On the T3_TICKS-th tick the block returns to F3, and expiry takes priority over line progress.
- R8: rx_sig = 0 in F5, F6, F7 or F8 returns the block to F3 at the next edge.
- R9: rx_lof = 1 in F6 or F7 (with a non-INFO-0 signal) moves to F8, which sends INFO 0 and reports 4'h3. In F8 with rx_lof = 0, INFO 2 returns to F6 and INFO 4 returns to F7.
- R10: host_cmd = 4'h1 (reset) moves any state to F3 at the next edge.
- R11: The test commands 4'h4 (tx_info 5, continuous pulses), 4'h5 (tx_info 6, isolated pulses) and 4'h6 (tx_info 3, looped) are accepted only in F3; test states report 4'hC. In a test state every command except 4'hC, 4'h0 and 4'h1 is ignored, and those three return to F3.
- R12: host_cmd = 4'h0 (deactivate) in F4 returns the block to F3.
- R13: ind_code follows the state one clock later and holds between changes. ind_stb is high for exactly the one cycle in which ind_code takes a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cmd | input | 4 | Command code held by the host register |
| rx_sig | input | 2 | Decoded line signal: 0 INFO 0, 1 other, 2 INFO 2, 3 INFO 4 |
| rx_lof | input | 1 | Frame alignment lost |
| t3_tick | input | 1 | One pulse per T3 timer tick |
| tx_info | output | 3 | Signal to transmit: 0 INFO 0, 1 INFO 1, 3 INFO 3, 5 continuous pulses, 6 isolated pulses |
| ind_code | output | 4 | Indication code for the host |
| ind_stb | output | 1 | One-cycle pulse on each indication change |
| activated | output | 1 | High in F7 |

## Verification
A wrong state shows up on tx_info and activated at the first sampling point after the faulty edge, because both outputs decode the state register directly. ind_code shows the same fault one cycle later, together with a missing or spurious ind_stb pulse. A wrong T3 count shows only as a return to INFO 0 one tick early or late, so the bench counts ticks exactly. A wrong stored priority class shows only as 4'h8 and 4'hA trading places in F7, so the bench runs activation with both request codes.

// File: rtl/isdn_l1_pkg.sv
package isdn_l1_pkg;

   localparam int CMD_W = 4;
   localparam int IND_W = 4;
   localparam int TX_W  = 3;
   localparam int RX_W  = 2;

   typedef enum logic [3:0] {
      ST_F3    = 4'd3,
      ST_F4    = 4'd4,
      ST_F5    = 4'd5,
      ST_F6    = 4'd6,
      ST_F7    = 4'd7,
      ST_F8    = 4'd8,
      ST_TCONT = 4'd10,
      ST_TISO  = 4'd11,
      ST_TLOOP = 4'd12
   } l1_state_e;

   // host commands
   localparam logic [CMD_W-1:0] CMD_DEACT = 4'h0;
   localparam logic [CMD_W-1:0] CMD_RESET = 4'h1;
   localparam logic [CMD_W-1:0] CMD_TCONT = 4'h4;
   localparam logic [CMD_W-1:0] CMD_TISO  = 4'h5;
   localparam logic [CMD_W-1:0] CMD_TLOOP = 4'h6;
   localparam logic [CMD_W-1:0] CMD_ACT8  = 4'h8;
   localparam logic [CMD_W-1:0] CMD_ACT10 = 4'h9;
   localparam logic [CMD_W-1:0] CMD_CLKEN = 4'hC;

   // decoded line signals
   localparam logic [RX_W-1:0] RX_INFO0 = 2'd0;
   localparam logic [RX_W-1:0] RX_OTHER = 2'd1;
   localparam logic [RX_W-1:0] RX_INFO2 = 2'd2;
   localparam logic [RX_W-1:0] RX_INFO4 = 2'd3;

   // transmit selections
   localparam logic [TX_W-1:0] TX_INFO0 = 3'd0;
   localparam logic [TX_W-1:0] TX_INFO1 = 3'd1;
   localparam logic [TX_W-1:0] TX_INFO3 = 3'd3;
   localparam logic [TX_W-1:0] TX_PCONT = 3'd5;
   localparam logic [TX_W-1:0] TX_PISO  = 3'd6;

   // host indications
   localparam logic [IND_W-1:0] IND_IDLE   = 4'hF;
   localparam logic [IND_W-1:0] IND_CLKRDY = 4'h7;
   localparam logic [IND_W-1:0] IND_WAIT   = 4'h1;
   localparam logic [IND_W-1:0] IND_DET    = 4'h2;
   localparam logic [IND_W-1:0] IND_LOF    = 4'h3;
   localparam logic [IND_W-1:0] IND_SYNC   = 4'h4;
   localparam logic [IND_W-1:0] IND_ACT8   = 4'h8;
   localparam logic [IND_W-1:0] IND_ACT10  = 4'hA;
   localparam logic [IND_W-1:0] IND_TEST   = 4'hC;

   function automatic logic is_test_cmd(input logic [CMD_W-1:0] c);
      return (c == CMD_TCONT) || (c == CMD_TISO) || (c == CMD_TLOOP);
   endfunction

   function automatic logic is_test_state(input l1_state_e s);
      return (s == ST_TCONT) || (s == ST_TISO) || (s == ST_TLOOP);
   endfunction

endpackage

// File: rtl/l1_t3_timer.sv
module l1_t3_timer #(
   parameter int T3_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic expire
);

   generate
      if (T3_TICKS < 1) begin : g_bad_param
         $error("l1_t3_timer: T3_TICKS must be at least 1");
      end

      if (T3_TICKS == 1) begin : g_single
         assign expire = run & tick;
      end else begin : g_count
         localparam int CNT_W = $clog2(T3_TICKS);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(T3_TICKS - 1);
         logic [CNT_W-1:0] cnt_q;

         assign expire = run & tick & (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!run || expire)
               cnt_q <= '0;
            else if (tick)
               cnt_q <= cnt_q + CNT_W'(1);
         end

         // R7
         t3_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST);
      end
   endgenerate

endmodule

// File: rtl/l1_act_fsm.sv
module l1_act_fsm
   import isdn_l1_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMD_W-1:0] cmd,
   input  logic [RX_W-1:0]  rx_sig,
   input  logic             rx_lof,
   input  logic             t3_expire,
   output l1_state_e        state_q,
   output logic             prio10_q,
   output logic             t3_run
);

   l1_state_e state_d;
   logic      in_test;
   logic      sig_present;

   assign sig_present = (rx_sig != RX_INFO0);
   assign in_test     = is_test_state(state_q);
   assign t3_run      = (state_q == ST_F4) || (state_q == ST_F5) || (state_q == ST_F6);

   always_comb begin
      state_d = state_q;
      if (cmd == CMD_RESET) begin
         state_d = ST_F3;
      end else begin
         unique case (state_q)
            ST_F3: begin
               if (cmd == CMD_TCONT)                           state_d = ST_TCONT;
               else if (cmd == CMD_TISO)                       state_d = ST_TISO;
               else if (cmd == CMD_TLOOP)                      state_d = ST_TLOOP;
               else if (sig_present)                           state_d = ST_F5;
               else if (cmd == CMD_ACT8 || cmd == CMD_ACT10)   state_d = ST_F4;
            end
            ST_F4: begin
               if (cmd == CMD_DEACT || t3_expire)              state_d = ST_F3;
               else if (sig_present)                           state_d = ST_F5;
            end
            ST_F5: begin
               if (t3_expire || !sig_present)                  state_d = ST_F3;
               else if (rx_sig == RX_INFO2)                    state_d = ST_F6;
               else if (rx_sig == RX_INFO4)                    state_d = ST_F7;
            end
            ST_F6: begin
               if (t3_expire || !sig_present)                  state_d = ST_F3;
               else if (rx_lof)                                state_d = ST_F8;
               else if (rx_sig == RX_INFO4)                    state_d = ST_F7;
            end
            ST_F7: begin
               if (!sig_present)                               state_d = ST_F3;
               else if (rx_lof)                                state_d = ST_F8;
               else if (rx_sig == RX_INFO2)                    state_d = ST_F6;
            end
            ST_F8: begin
               if (!sig_present)                               state_d = ST_F3;
               else if (!rx_lof && rx_sig == RX_INFO2)         state_d = ST_F6;
               else if (!rx_lof && rx_sig == RX_INFO4)         state_d = ST_F7;
            end
            default: begin
               if (cmd == CMD_DEACT || cmd == CMD_CLKEN)       state_d = ST_F3;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_F3;
         prio10_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_F3 && (cmd == CMD_ACT8 || cmd == CMD_ACT10))
            prio10_q <= (cmd == CMD_ACT10);
      end
   end

   // R10
   reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_RESET |=> state_q == ST_F3);

   // R7
   t3_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t3_expire |=> state_q == ST_F3);

   // R4
   line_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_F3 && sig_present && cmd != CMD_RESET && !is_test_cmd(cmd))
      |=> state_q == ST_F5);

   // R11
   test_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_test) |-> $past(state_q) == ST_F3);

endmodule

// File: rtl/l1_out_decode.sv
module l1_out_decode
   import isdn_l1_pkg::*;
(
   input  l1_state_e        state,
   input  logic [CMD_W-1:0] cmd,
   input  logic             prio10,
   output logic [TX_W-1:0]  tx_info,
   output logic [IND_W-1:0] ind_next,
   output logic             activated
);

   assign activated = (state == ST_F7);

   always_comb begin
      tx_info  = TX_INFO0;
      ind_next = IND_IDLE;
      unique case (state)
         ST_F3: begin
            tx_info  = TX_INFO0;
            ind_next = (cmd == CMD_CLKEN) ? IND_CLKRDY : IND_IDLE;
         end
         ST_F4: begin
            tx_info  = TX_INFO1;
            ind_next = IND_WAIT;
         end
         ST_F5: begin
            tx_info  = TX_INFO0;
            ind_next = IND_DET;
         end
         ST_F6: begin
            tx_info  = TX_INFO3;
            ind_next = IND_SYNC;
         end
         ST_F7: begin
            tx_info  = TX_INFO3;
            ind_next = prio10 ? IND_ACT10 : IND_ACT8;
         end
         ST_F8: begin
            tx_info  = TX_INFO0;
            ind_next = IND_LOF;
         end
         ST_TCONT: begin
            tx_info  = TX_PCONT;
            ind_next = IND_TEST;
         end
         ST_TISO: begin
            tx_info  = TX_PISO;
            ind_next = IND_TEST;
         end
         ST_TLOOP: begin
            tx_info  = TX_INFO3;
            ind_next = IND_TEST;
         end
         default: begin
            tx_info  = TX_INFO0;
            ind_next = IND_IDLE;
         end
      endcase
   end

endmodule

// File: rtl/l1_ind_reg.sv
module l1_ind_reg
   import isdn_l1_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IND_W-1:0] ind_next,
   output logic [IND_W-1:0] ind_q,
   output logic             stb_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ind_q <= IND_IDLE;
         stb_q <= 1'b0;
      end else begin
         stb_q <= (ind_next != ind_q);
         ind_q <= ind_next;
      end
   end

   // R13
   stb_marks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_q |-> ind_q != $past(ind_q));

   // R13
   hold_without_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_q |-> $stable(ind_q));

endmodule

// File: rtl/isdn_te_act_ctrl.sv
module isdn_te_act_ctrl
   import isdn_l1_pkg::*;
#(
   parameter int T3_TICKS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMD_W-1:0] host_cmd,
   input  logic [RX_W-1:0]  rx_sig,
   input  logic             rx_lof,
   input  logic             t3_tick,
   output logic [TX_W-1:0]  tx_info,
   output logic [IND_W-1:0] ind_code,
   output logic             ind_stb,
   output logic             activated
);

   l1_state_e        state;
   logic             prio10;
   logic             t3_run;
   logic             t3_expire;
   logic [IND_W-1:0] ind_next;

   l1_t3_timer #(.T3_TICKS(T3_TICKS)) u_t3 (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (t3_run),
      .tick   (t3_tick),
      .expire (t3_expire)
   );

   l1_act_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (host_cmd),
      .rx_sig    (rx_sig),
      .rx_lof    (rx_lof),
      .t3_expire (t3_expire),
      .state_q   (state),
      .prio10_q  (prio10),
      .t3_run    (t3_run)
   );

   l1_out_decode u_dec (
      .state     (state),
      .cmd       (host_cmd),
      .prio10    (prio10),
      .tx_info   (tx_info),
      .ind_next  (ind_next),
      .activated (activated)
   );

   l1_ind_reg u_ind (
      .clk      (clk),
      .rst_n    (rst_n),
      .ind_next (ind_next),
      .ind_q    (ind_code),
      .stb_q    (ind_stb)
   );

   // R6
   act_needs_info4_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(activated) |-> $past(rx_sig) == RX_INFO4);

   // R9
   lof_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (activated && rx_lof && rx_sig != RX_INFO0 && host_cmd != CMD_RESET)
      |=> (!activated && tx_info == TX_INFO0));

endmodule

// File: tb/isdn_te_act_ctrl_tb.sv
module isdn_te_act_ctrl_tb;

   localparam int T3 = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] host_cmd = 4'hF;
   logic [1:0] rx_sig = 2'd0;
   logic       rx_lof = 1'b0;
   logic       t3_tick = 1'b0;
   logic [2:0] tx_info;
   logic [3:0] ind_code;
   logic       ind_stb;
   logic       activated;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   isdn_te_act_ctrl #(.T3_TICKS(T3)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_cmd  (host_cmd),
      .rx_sig    (rx_sig),
      .rx_lof    (rx_lof),
      .t3_tick   (t3_tick),
      .tx_info   (tx_info),
      .ind_code  (ind_code),
      .ind_stb   (ind_stb),
      .activated (activated)
   );

   // ---------------- reference model ----------------
   // states: 3..8 are F3..F8, 20/21/22 the three test transmissions
   int   m_state;
   int   m_cnt;
   bit   m_prio10;
   int   m_ind;
   bit   m_stb;

   function automatic bit pending(int s);
      return s == 4 || s == 5 || s == 6;
   endfunction

   function automatic int next_of(int s, int c, int r, bit l, bit ex);
      if (c == 1) return 3;
      case (s)
         3: begin
            if (c == 4) return 20;
            if (c == 5) return 21;
            if (c == 6) return 22;
            if (r != 0) return 5;
            if (c == 8 || c == 9) return 4;
            return 3;
         end
         4: begin
            if (c == 0 || ex) return 3;
            if (r != 0) return 5;
            return 4;
         end
         5: begin
            if (ex || r == 0) return 3;
            if (r == 2) return 6;
            if (r == 3) return 7;
            return 5;
         end
         6: begin
            if (ex || r == 0) return 3;
            if (l) return 8;
            if (r == 3) return 7;
            return 6;
         end
         7: begin
            if (r == 0) return 3;
            if (l) return 8;
            if (r == 2) return 6;
            return 7;
         end
         8: begin
            if (r == 0) return 3;
            if (!l && r == 2) return 6;
            if (!l && r == 3) return 7;
            return 8;
         end
         default: begin
            if (c == 0 || c == 12) return 3;
            return s;
         end
      endcase
   endfunction

   function automatic int ind_of(int s, int c, bit p10);
      case (s)
         3: return (c == 12) ? 7 : 15;
         4: return 1;
         5: return 2;
         6: return 4;
         7: return p10 ? 10 : 8;
         8: return 3;
         default: return 12;
      endcase
   endfunction

   function automatic int tx_of(int s);
      case (s)
         4: return 1;
         6, 7, 22: return 3;
         20: return 5;
         21: return 6;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state  <= 3;
         m_cnt    <= 0;
         m_prio10 <= 0;
         m_ind    <= 15;
         m_stb    <= 0;
      end else begin
         bit ex;
         int ni;
         ex = pending(m_state) && t3_tick && (m_cnt == T3 - 1);
         ni = ind_of(m_state, int'(host_cmd), m_prio10);
         m_stb <= (ni != m_ind);
         m_ind <= ni;
         if (m_state == 3 && (host_cmd == 4'h8 || host_cmd == 4'h9))
            m_prio10 <= (host_cmd == 4'h9);
         if (!pending(m_state) || ex) m_cnt <= 0;
         else if (t3_tick) m_cnt <= m_cnt + 1;
         m_state <= next_of(m_state, int'(host_cmd), int'(rx_sig), rx_lof, ex);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (int'(tx_info) != tx_of(m_state) || activated != (m_state == 7) ||
             int'(ind_code) != m_ind || ind_stb != m_stb) begin
            errors++;
            $display("FAIL %s cycle compare: actual tx=%0d act=%0d ind=%0h stb=%0d expected tx=%0d act=%0d ind=%0h stb=%0d",
                     cur_req, tx_info, activated, ind_code, ind_stb,
                     tx_of(m_state), (m_state == 7), m_ind, m_stb);
         end
      end
   end

   // ---------------- directed helpers ----------------
   task automatic clk1();
      @(negedge clk);
      #1;
   endtask

   task automatic clkn(int n);
      for (int i = 0; i < n; i++) clk1();
   endtask

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      clk1();
      cur_req = "R1";
      chk("R1 tx after reset", tx_info, 0);
      chk("R1 ind after reset", ind_code, 15);
      chk("R1 stb after reset", ind_stb, 0);
      chk("R1 activated after reset", activated, 0);

      cur_req = "R2";
      host_cmd = 4'hC; clk1();
      chk("R2 clock-ready ind", ind_code, 7);
      chk("R2 tx stays INFO0", tx_info, 0);
      chk("r13_ strobe on change", ind_stb, 1);
      clk1();
      chk("R13 strobe one cycle", ind_stb, 0);

      cur_req = "R3";
      host_cmd = 4'h8; clk1();
      chk("R3 INFO1 sent", tx_info, 1);
      host_cmd = 4'hF; clk1();
      chk("R3 waiting ind", ind_code, 1);

      cur_req = "R4";
      rx_sig = 2'd1; clk1();
      chk("R4 F5 sends INFO0", tx_info, 0);
      clk1();
      chk("R4 detect ind", ind_code, 2);

      cur_req = "R5";
      rx_sig = 2'd2; clk1();
      chk("R5 F6 sends INFO3", tx_info, 3);
      chk("R5 not yet activated", activated, 0);
      rx_sig = 2'd3; clk1();
      cur_req = "R6";
      chk("R6 activated", activated, 1);
      clk1();
      chk("R6 class-8 ind", ind_code, 8);

      cur_req = "R9";
      rx_lof = 1'b1; clk1();
      chk("R9 lof drops activation", activated, 0);
      chk("R9 F8 sends INFO0", tx_info, 0);
      clk1();
      chk("R9 lof ind", ind_code, 3);
      rx_lof = 1'b0; clk1();
      chk("R9 regain to F7", activated, 1);

      cur_req = "R8";
      rx_sig = 2'd0; clk1();
      chk("R8 INFO0 deactivates", activated, 0);
      clk1();
      chk("R8 idle ind", ind_code, 15);

      cur_req = "R7";
      host_cmd = 4'h9; clk1();
      chk("R7 in F4", tx_info, 1);
      host_cmd = 4'hF; t3_tick = 1'b1;
      clkn(T3 - 1);
      chk("R7 still F4 before last tick", tx_info, 1);
      clk1();
      chk("R7 expiry returns to INFO0", tx_info, 0);
      t3_tick = 1'b0;
      clk1();

      cur_req = "R6";
      host_cmd = 4'h9; clk1();
      host_cmd = 4'hF; rx_sig = 2'd1; clk1();
      rx_sig = 2'd3; clk1();
      chk("R6 activated class 10", activated, 1);
      clk1();
      chk("R6 class-10 ind", ind_code, 10);
      rx_sig = 2'd2; clk1();
      chk("R6 INFO2 in F7 back to F6", activated, 0);
      rx_sig = 2'd3; clk1();

      cur_req = "R10";
      host_cmd = 4'h1; clk1();
      chk("R10 reset from F7", activated, 0);
      chk("R10 tx INFO0", tx_info, 0);
      host_cmd = 4'hF; rx_sig = 2'd0; clk1();

      cur_req = "R11";
      host_cmd = 4'h4; clk1();
      chk("R11 continuous pulses", tx_info, 5);
      clk1();
      chk("R11 test ind", ind_code, 12);
      host_cmd = 4'h8; rx_sig = 2'd1; clk1();
      chk("R11 request ignored in test", tx_info, 5);
      rx_sig = 2'd0; host_cmd = 4'hC; clk1();
      chk("R11 clock-enable leaves test", tx_info, 0);
      host_cmd = 4'h5; clk1();
      chk("R11 isolated pulses", tx_info, 6);
      host_cmd = 4'h0; clk1();
      chk("R11 deactivate leaves test", tx_info, 0);
      host_cmd = 4'h6; clk1();
      chk("R11 looped INFO3", tx_info, 3);
      chk("R11 loop not activated", activated, 0);
      host_cmd = 4'h1; clk1();
      chk("R11 reset leaves test", tx_info, 0);
      host_cmd = 4'h8; clk1();
      host_cmd = 4'h4; clk1();
      chk("R11 test command ignored in F4", tx_info, 1);

      cur_req = "R12";
      host_cmd = 4'h0; clk1();
      chk("R12 deactivate from F4", tx_info, 0);
      host_cmd = 4'hF; clk1();

      cur_req = "R8";
      host_cmd = 4'h8; clk1();
      host_cmd = 4'hF; rx_sig = 2'd1; clk1();
      rx_sig = 2'd0; clk1(); clk1();
      chk("R8 INFO0 in F5 back to idle", ind_code, 15);

      cur_req = "R4/R5/R7/R9/R13 mixed";
      for (int i = 0; i < 3000; i++) begin
         int pick;
         pick = $urandom_range(0, 31);
         case (pick)
            0:       host_cmd = 4'h1;
            1, 2:    host_cmd = 4'h0;
            3:       host_cmd = 4'h4;
            4:       host_cmd = 4'h5;
            5:       host_cmd = 4'h6;
            6, 7:    host_cmd = 4'h8;
            8, 9:    host_cmd = 4'h9;
            10, 11:  host_cmd = 4'hC;
            default: host_cmd = 4'hF;
         endcase
         rx_sig  = 2'($urandom_range(0, 3));
         rx_lof  = ($urandom_range(0, 5) == 0);
         t3_tick = ($urandom_range(0, 2) == 0);
         clk1();
      end

      finish_run();
   end

endmodule